// File: doc/BRIEF.md
# Jittered PWM Timing Generator

This block is the digital cycle engine of a current-mode flyback controller. It counts a fixed system clock to build a switching period near 65 kHz and opens the gate at the start of every period. The pulse ends when a digital current-trip flag is seen or when a duty ceiling is reached, whichever comes first. To spread conducted emissions, the period length follows a slow triangular sweep of about ±7 % around the centre value. The period is adjusted by a fixed count once per completed cycle.

Each pulse has two protections. During a short window right after turn-on, the trip flag is ignored and that window is shown on a separate output. After the window, a minimum on-time still applies before a trip may end the pulse. A blank request lets the light-load logic suppress whole pulses while the period counter keeps running. An enable input stops everything at once and rearms the counter.

All times are held as counts of the system clock and derived from frequency and nanosecond parameters. The analog comparator, slope ramp and driver stage stay outside the block.

Top module: `jitter_pwm_timer`

## Requirements
- R1: While reset is held, and while `en_i` stays low after reset, `gate_o`, `cycle_start_o` and `leb_o` are all low.
- R2: On the first clock in which `en_i` is seen high, a cycle begins. In the next clock `cycle_start_o`, `gate_o` and `leb_o` are high together. The gate never rises except in a clock where `cycle_start_o` is high.
- R3: The first cycle after reset lasts P_NOM = CLK_HZ / FSW_HZ clocks (integer division), measured from one `cycle_start_o` pulse to the next.
- R4: Each completed cycle moves the period by JIT_STEP clocks. The sweep starts upward and is clamped to P_NOM ± floor(P_NOM·JIT_PCT/100). It reverses direction in the cycle that reaches a bound.
- R5: With no effective trip, the gate stays high for floor(P·DMAX_PCT/100) clocks, where P is the length of the current cycle.
- R6: `leb_o` is high for the first LEB = floor((CLK_HZ/1000)·LEB_NS/10^6) clocks of each pulse. A trip that ends inside this window does not shorten the pulse.
- R7: A pulse lasts at least MINON = floor((CLK_HZ/1000)·MINON_NS/10^6) clocks. A trip that starts earlier and stays high ends the pulse after exactly MINON clocks. A trip pulse that falls before then has no effect.
- R8: A trip that is high in pulse clock c (counted from 0) with c ≥ max(LEB, MINON−1) makes `gate_o` low from the next clock.
- R9: A high `blank_i` in the last clock of a cycle keeps the gate low for the whole next cycle. `cycle_start_o` still pulses and the period sweep still advances.
- R10: When `en_i` is low, `gate_o` and `cycle_start_o` are low from the next clock on. The interrupted cycle does not step the sweep. Re-enabling starts a fresh cycle with the period left where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces the gate off and rearms the counter |
| blank_i | input | 1 | Suppresses the pulse of the next cycle |
| trip_i | input | 1 | Current-sense trip flag, level sensitive |
| gate_o | output | 1 | Gate command |
| cycle_start_o | output | 1 | One-clock strobe in the first clock of every cycle |
| leb_o | output | 1 | High during the trip-blanking window of a pulse |

## Verification
The bench runs the block with a scaled switching frequency of 100-clock cycles, so several full sweeps fit in one run. Pulses are tried with no trip, with trips held only inside the blanking window, with trips held from before the minimum on-time, with short trips after both limits, with trips placed past the duty ceiling, and with short trips between blanking and minimum on-time. Together these separate the four ways a pulse can end: the duty ceiling, the blanking rule, the minimum-on rule and a plain trip. Random blank requests and a mid-pulse disable show that the period sweep advances independently of the gate and pauses only while the block is disabled.

// File: rtl/pwm_jit_pkg.sv
`timescale 1ns/1ps
package pwm_jit_pkg;

   typedef enum logic {
      SWEEP_UP = 1'b0,
      SWEEP_DN = 1'b1
   } sweep_dir_e;

   // duty ceiling in clocks for a given period length
   function automatic int calc_ton(input int per, input int pct);
      return (per * pct) / 100;
   endfunction

   // nanoseconds to whole clocks at CLK_HZ
   function automatic int ns_to_clk(input int clk_hz, input int ns);
      return ((clk_hz / 1000) * ns) / 1_000_000;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwm_jit_sweep.sv
`timescale 1ns/1ps
module pwm_jit_sweep
   import pwm_jit_pkg::*;
#(
   parameter int P_NOM    = 769,
   parameter int P_MIN    = 716,
   parameter int P_MAX    = 822,
   parameter int STEP     = 1,
   parameter int DMAX_PCT = 75,
   parameter int W        = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] period_o,
   output logic [W-1:0] ton_max_o
);

   localparam int TON_NOM = calc_ton(P_NOM, DMAX_PCT);

   generate
      if (P_MIN == P_MAX) begin : g_fixed
         // no sweep: constant period and ceiling
         logic unused_step;
         assign unused_step = step_i;
         assign period_o    = W'(P_NOM);
         assign ton_max_o   = W'(TON_NOM);
      end else begin : g_tri
         logic [W-1:0] per_q, per_d;
         logic [W-1:0] ton_q;
         sweep_dir_e   dir_q, dir_d;

         always_comb begin
            per_d = per_q;
            dir_d = dir_q;
            if (dir_q == SWEEP_UP) begin
               if (int'(per_q) + STEP >= P_MAX) begin
                  per_d = W'(P_MAX);
                  dir_d = SWEEP_DN;
               end else begin
                  per_d = per_q + W'(STEP);
               end
            end else begin
               if (int'(per_q) - STEP <= P_MIN) begin
                  per_d = W'(P_MIN);
                  dir_d = SWEEP_UP;
               end else begin
                  per_d = per_q - W'(STEP);
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_q <= W'(P_NOM);
               ton_q <= W'(TON_NOM);
               dir_q <= SWEEP_UP;
            end else if (step_i) begin
               per_q <= per_d;
               ton_q <= W'(calc_ton(int'(per_d), DMAX_PCT));
               dir_q <= dir_d;
            end
         end

         assign period_o  = per_q;
         assign ton_max_o = ton_q;
      end
   endgenerate

endmodule

// File: rtl/pwm_period_ctr.sv
`timescale 1ns/1ps
module pwm_period_ctr #(
   parameter int P_NOM = 769,
   parameter int W     = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] period_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o,
   output logic         step_o,
   output logic         start_o
);

   logic [W-1:0] cnt_q;
   logic         run_q;
   logic         at_last;

   assign at_last = (cnt_q == period_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(P_NOM - 1);
         run_q <= 1'b0;
      end else begin
         run_q <= en_i;
         if (!en_i) begin
            cnt_q <= period_i - 1'b1;   // parked on the last count
         end else if (at_last) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o   = cnt_q;
   assign wrap_o  = en_i && at_last;
   // only a cycle that actually ran advances the sweep
   assign step_o  = wrap_o && run_q;
   assign start_o = (cnt_q == '0);

endmodule

// File: rtl/pwm_gate_ctl.sv
`timescale 1ns/1ps
module pwm_gate_ctl #(
   parameter int LEB_CYC   = 12,
   parameter int TRIP_FROM = 16,
   parameter int W         = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         blank_i,
   input  logic         trip_i,
   input  logic         wrap_i,
   input  logic [W-1:0] cnt_i,
   input  logic [W-1:0] ton_max_i,
   output logic         gate_o,
   output logic         leb_o
);

   logic on_q;
   logic ceil_hit;
   logic trip_ok;

   assign ceil_hit = (cnt_i >= ton_max_i - 1'b1);
   assign trip_ok  = trip_i && (int'(cnt_i) >= TRIP_FROM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q <= 1'b0;
      end else if (!en_i) begin
         on_q <= 1'b0;
      end else if (wrap_i) begin
         on_q <= !blank_i;
      end else if (on_q && (ceil_hit || trip_ok)) begin
         on_q <= 1'b0;
      end
   end

   assign gate_o = on_q;

   generate
      if (LEB_CYC == 0) begin : g_no_leb
         assign leb_o = 1'b0;
      end else begin : g_leb
         assign leb_o = on_q && (int'(cnt_i) < LEB_CYC);
      end
   endgenerate

endmodule

// File: rtl/jitter_pwm_timer.sv
`timescale 1ns/1ps
module jitter_pwm_timer
   import pwm_jit_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int FSW_HZ   = 65_000,
   parameter int JIT_PCT  = 7,
   parameter int JIT_STEP = 1,
   parameter int DMAX_PCT = 75,
   parameter int LEB_NS   = 250,
   parameter int MINON_NS = 350
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic blank_i,
   input  logic trip_i,
   output logic gate_o,
   output logic cycle_start_o,
   output logic leb_o
);

   localparam int P_NOM     = CLK_HZ / FSW_HZ;
   localparam int P_DEV     = (P_NOM * JIT_PCT) / 100;
   localparam int P_MIN     = P_NOM - P_DEV;
   localparam int P_MAX     = P_NOM + P_DEV;
   localparam int W         = $clog2(P_MAX + 1);
   localparam int LEB_CYC   = ns_to_clk(CLK_HZ, LEB_NS);
   localparam int MINON_CYC = ns_to_clk(CLK_HZ, MINON_NS);
   localparam int TRIP_FROM = imax(LEB_CYC, MINON_CYC - 1);
   localparam int TON_MIN   = calc_ton(P_MIN, DMAX_PCT);
   localparam int TON_MAX   = calc_ton(P_MAX, DMAX_PCT);

   generate
      if (P_NOM < 4) begin : g_chk_per
         $error("period too short for the clock");
      end
      if (DMAX_PCT < 1 || DMAX_PCT > 99) begin : g_chk_duty
         $error("duty ceiling must be 1..99 percent");
      end
      if (JIT_PCT < 0 || JIT_PCT > 50) begin : g_chk_jit
         $error("jitter depth out of range");
      end
      if (JIT_STEP < 1) begin : g_chk_step
         $error("jitter step must be positive");
      end
      if (TON_MIN <= TRIP_FROM) begin : g_chk_ton
         $error("duty ceiling shorter than blanking plus minimum on-time");
      end
   endgenerate

   logic [W-1:0] period;
   logic [W-1:0] ton_max;
   logic [W-1:0] cnt;
   logic         wrap;
   logic         step;

   pwm_jit_sweep #(
      .P_NOM    (P_NOM),
      .P_MIN    (P_MIN),
      .P_MAX    (P_MAX),
      .STEP     (JIT_STEP),
      .DMAX_PCT (DMAX_PCT),
      .W        (W)
   ) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step),
      .period_o  (period),
      .ton_max_o (ton_max)
   );

   pwm_period_ctr #(
      .P_NOM (P_NOM),
      .W     (W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .period_i (period),
      .cnt_o    (cnt),
      .wrap_o   (wrap),
      .step_o   (step),
      .start_o  (cycle_start_o)
   );

   pwm_gate_ctl #(
      .LEB_CYC   (LEB_CYC),
      .TRIP_FROM (TRIP_FROM),
      .W         (W)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .blank_i   (blank_i),
      .trip_i    (trip_i),
      .wrap_i    (wrap),
      .cnt_i     (cnt),
      .ton_max_i (ton_max),
      .gate_o    (gate_o),
      .leb_o     (leb_o)
   );

endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk #(
   parameter int P_MIN     = 716,
   parameter int P_MAX     = 822,
   parameter int TON_HI    = 616,
   parameter int LEB_CYC   = 12,
   parameter int MINON_CYC = 17,
   parameter int TRIP_FROM = 16
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic blank_i,
   input logic trip_i,
   input logic gate_o,
   input logic cycle_start_o,
   input logic leb_o
);

   int unsigned on_len_q;
   int unsigned per_len_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_len_q  <= 0;
         per_len_q <= 0;
         seen_q    <= 1'b0;
      end else begin
         on_len_q <= gate_o ? on_len_q + 1 : 0;
         if (!en_i) begin
            per_len_q <= 0;
            seen_q    <= 1'b0;
         end else if (cycle_start_o) begin
            per_len_q <= 1;
            seen_q    <= 1'b1;
         end else if (per_len_q < 32'hFFFF) begin
            per_len_q <= per_len_q + 1;
         end
      end
   end

   a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> cycle_start_o);

   a_r4_period_in_band: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_start_o && seen_q && en_i) |-> (per_len_q >= P_MIN && per_len_q <= P_MAX));

   a_r5_duty_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o |-> (on_len_q < TON_HI));

   a_r6_leb_inside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      leb_o |-> (gate_o && on_len_q < LEB_CYC));

   a_r6_leb_opens_with_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_o) && LEB_CYC > 0) |-> leb_o);

   a_r7_min_on: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $fell(gate_o)) |-> (on_len_q >= MINON_CYC));

   a_r8_trip_cuts: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && trip_i && on_len_q >= TRIP_FROM) |=> !gate_o);

   a_r9_blank_skips: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_start_o && $past(blank_i)) |-> !gate_o);

   a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!gate_o && !cycle_start_o));

endmodule

bind jitter_pwm_timer pwm_timer_chk #(
   .P_MIN     (P_MIN),
   .P_MAX     (P_MAX),
   .TON_HI    (TON_MAX),
   .LEB_CYC   (LEB_CYC),
   .MINON_CYC (MINON_CYC),
   .TRIP_FROM (TRIP_FROM)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en_i          (en_i),
   .blank_i       (blank_i),
   .trip_i        (trip_i),
   .gate_o        (gate_o),
   .cycle_start_o (cycle_start_o),
   .leb_o         (leb_o)
);

// File: tb/tb_jitter_pwm_timer.sv
`timescale 1ns/1ps
module tb_jitter_pwm_timer;

   // scaled build: 50 MHz counts, 500 kHz centre -> 100-clock cycles
   localparam int P_NOM     = 100;
   localparam int P_MIN     = 93;
   localparam int P_MAX     = 107;
   localparam int LEB       = 12;
   localparam int MINON     = 17;
   localparam int TRIP_FROM = 16;
   localparam int DMAX      = 75;

   logic clk     = 1'b0;
   logic rst_n   = 1'b0;
   logic en_i    = 1'b0;
   logic blank_i = 1'b0;
   logic trip_i  = 1'b0;
   logic gate_o, cycle_start_o, leb_o;

   int n_chk   = 0;
   int n_fail  = 0;
   int m_per   = P_NOM;
   bit m_up    = 1'b1;
   bit m_blank = 1'b0;
   bit first_c = 1'b1;
   int cyc_idx = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   jitter_pwm_timer #(
      .CLK_HZ (50_000_000),
      .FSW_HZ (500_000)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (en_i),
      .blank_i       (blank_i),
      .trip_i        (trip_i),
      .gate_o        (gate_o),
      .cycle_start_o (cycle_start_o),
      .leb_o         (leb_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic sweep_step();
      if (m_up) begin
         m_per++;
         if (m_per >= P_MAX) begin m_per = P_MAX; m_up = 1'b0; end
      end else begin
         m_per--;
         if (m_per <= P_MIN) begin m_per = P_MIN; m_up = 1'b1; end
      end
   endtask

   function automatic int exp_on(input int tmax, input int ts, input int tl);
      for (int c = 0; c < tmax; c++) begin
         if (c >= ts && c < ts + tl && c >= LEB && c >= MINON - 1) return c + 1;
      end
      return tmax;
   endfunction

   // entry and exit: at the negedge inside the first clock of a cycle
   task automatic run_cycles(input int n);
      for (int k = 0; k < n; k++) begin
         int    tmax, ts, tl, kind, c, on_len, leb_len, e_on, e_leb;
         bit    blanked, bn;
         string tag;
         tmax    = (m_per * DMAX) / 100;
         blanked = m_blank;
         kind    = (cyc_idx < 5) ? cyc_idx : int'($urandom_range(0, 4));
         ts = 0; tl = 0; tag = "R5";
         case (kind)
            1: begin ts = int'($urandom_range(0, LEB - 2));
                     tl = int'($urandom_range(1, LEB - ts)); tag = "R6"; end
            2: begin ts = int'($urandom_range(LEB, TRIP_FROM - 1)); tl = 200; tag = "R7"; end
            3: begin ts = TRIP_FROM + int'($urandom_range(0, tmax + 3 - TRIP_FROM));
                     tl = int'($urandom_range(1, 5)); tag = (ts < tmax) ? "R8" : "R5"; end
            4: begin ts = LEB; tl = TRIP_FROM - LEB; tag = "R7"; end
            default: ;
         endcase
         if (blanked) tag = "R9";
         bn = (cyc_idx == 5) || (cyc_idx > 6 && $urandom_range(0, 7) == 0);
         blank_i = bn;
         e_on  = blanked ? 0 : exp_on(tmax, ts, tl);
         e_leb = (e_on < LEB) ? e_on : LEB;
         on_len = 0; leb_len = 0; c = 0;
         forever begin
            if (gate_o) on_len++;
            if (leb_o) leb_len++;
            trip_i = (c >= ts && c < ts + tl);
            @(negedge clk);
            c++;
            if (cycle_start_o || c > 300) break;
         end
         trip_i = 1'b0;
         chk(first_c ? "R3" : (blanked ? "R9" : "R4"), "period", c, m_per);
         chk(tag, "on-time", on_len, e_on);
         chk(blanked ? "R9" : "R6", "blank window", leb_len, e_leb);
         first_c = 1'b0;
         m_blank = bn;
         sweep_step();
         cyc_idx++;
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int low_bad;
      void'($urandom(32'd2024));
      // R1: outputs quiet in reset
      repeat (4) @(negedge clk);
      chk("R1", "gate in reset", int'(gate_o), 0);
      chk("R1", "strobe in reset", int'(cycle_start_o), 0);
      rst_n = 1'b1;
      low_bad = 0;
      repeat (8) begin
         @(negedge clk);
         if (gate_o || cycle_start_o || leb_o) low_bad++;
      end
      chk("R1", "idle outputs after reset", low_bad, 0);

      // R2: enable starts a cycle in the next clock
      en_i = 1'b1;
      @(negedge clk);
      chk("R2", "strobe after enable", int'(cycle_start_o), 1);
      chk("R2", "gate after enable", int'(gate_o), 1);
      chk("R2", "blank window after enable", int'(leb_o), 1);
      run_cycles(45);

      // R10: disable inside a pulse
      repeat (5) @(negedge clk);
      en_i = 1'b0;
      @(negedge clk);
      chk("R10", "gate after disable", int'(gate_o), 0);
      chk("R10", "strobe after disable", int'(cycle_start_o), 0);
      low_bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (gate_o || cycle_start_o || leb_o) low_bad++;
      end
      chk("R10", "outputs while disabled", low_bad, 0);
      blank_i = 1'b0;
      m_blank = 1'b0;
      en_i = 1'b1;
      @(negedge clk);
      chk("R2", "strobe after re-enable", int'(cycle_start_o), 1);
      chk("R10", "gate after re-enable", int'(gate_o), 1);
      run_cycles(70);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule